// File: doc/BRIEF.md
# 8-bit Dual-Compare Timer Counter

This block is an 8-bit up-counter with two compare registers, an overflow flag and three interrupt requests. One control byte selects what advances the counter: one of three prescaled clock enables, or an external clock pin on its rising edge, falling edge or both edges. The same byte also selects how the counter is cleared: never, on a compare match with register A or with register B, or on a rising edge of an external reset pin. Each of the three interrupts has its own mask bit.

Three status flags record compare-match A, compare-match B and overflow. Hardware sets them. Software clears a flag by reading it as 1 and then writing 0 to it. The bus is a simple single-cycle register port. Read data is combinational from the addressed register. The external clock and reset pins are synchronized inside the block, so they may change asynchronously to the system clock.

Top module: `cmp8_timer`

## Requirements
- R1: After reset the control byte (address 0) reads 0x00, the status byte (address 1) reads 0x00, the count (address 2) reads 0x00, and both compare registers (A at address 3, B at address 4) read 0xFF. All interrupt outputs are low.
- R2: Control bits 2:0 select the count source. Code 000 stops the counter, and so does the reserved code 111. Codes 001, 010 and 011 advance it by one on each cycle where `pre_en[0]`, `pre_en[1]` or `pre_en[2]` is high, respectively.
- R3: Codes 100, 101 and 110 advance the counter once for each rising edge, each falling edge, or each edge of either kind of `ext_clk`. The pin passes through a two-flop synchronizer first.
- R4: On a count step where the count equals compare A, status bit 6 sets. Where it equals compare B, status bit 7 sets. Unless the match clears it, the counter steps by one.
- R5: Control bits 4:3 = 01 (or 10) make a count step that matches A (or B) load 0 instead of incrementing, so the counter cycles through 0 up to the compare value.
- R6: Control bits 4:3 = 11 clear the counter on each rising edge of the synchronized `ext_rst`, independent of the count source. In other modes, and on falling edges, `ext_rst` has no effect.
- R7: A count step at 0xFF that is not turned into a clear wraps the counter to 0x00 and sets status bit 5. With bits 4:3 = 00 the counter is never cleared.
- R8: `irq_cmp_b`, `irq_cmp_a` and `irq_ovf` are high only while status bit 7, 6 or 5 and control bit 7, 6 or 5, respectively, are both 1. A flag still sets while its mask bit is 0.
- R9: Writing 0 to a status bit clears it only if that bit has been read as 1 since it last became set. Writing 1 to a status bit has no effect.
- R10: When hardware sets a flag in the same cycle as a valid software clear, the flag stays 1.
- R11: A bus write to the count register takes effect over a count step or clear in the same cycle. Unused addresses 5 to 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms flag clearing) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| pre_en | input | 3 | Three prescaled clock enables |
| ext_clk | input | 1 | External count clock pin |
| ext_rst | input | 1 | External counter clear pin |
| irq_cmp_a | output | 1 | Compare-match A interrupt request |
| irq_cmp_b | output | 1 | Compare-match B interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The checker watches several properties on every cycle. The counter may only hold, step by one or go to zero unless the bus writes it. A stopped source freezes the count. With clearing disabled the counter never drops to zero except by wrapping. A match or a wrap always leaves its flag set on the next cycle. A flag never falls without a status write. An interrupt never rises without its flag and mask. Other behaviour shows only in the bench's directed scenarios: which prescaled enable or pin edge each source code picks, the exact period of the clear-on-match modes, and the effect of the synchronized reset pin. The same holds for the read-then-write rule for clearing a flag and for the ordering between hardware set, software clear and bus writes.

// File: rtl/cmp8_timer_pkg.sv
package cmp8_timer_pkg;
    localparam int DW = 8;
    localparam int AW = 3;

    localparam logic [AW-1:0] A_CTRL = 3'd0;
    localparam logic [AW-1:0] A_STAT = 3'd1;
    localparam logic [AW-1:0] A_CNT  = 3'd2;
    localparam logic [AW-1:0] A_CMPA = 3'd3;
    localparam logic [AW-1:0] A_CMPB = 3'd4;

    // flag indices; status byte holds flags at bits FLAG_LSB and up
    localparam int NFLAG    = 3;
    localparam int F_OVF    = 0;
    localparam int F_A      = 1;
    localparam int F_B      = 2;
    localparam int FLAG_LSB = 5;

    typedef enum logic [1:0] {
        CLR_NONE    = 2'b00,
        CLR_MATCH_A = 2'b01,
        CLR_MATCH_B = 2'b10,
        CLR_PIN     = 2'b11
    } clr_mode_e;

    typedef enum logic [2:0] {
        SRC_STOP     = 3'b000,
        SRC_PRE0     = 3'b001,
        SRC_PRE1     = 3'b010,
        SRC_PRE2     = 3'b011,
        SRC_EXT_RISE = 3'b100,
        SRC_EXT_FALL = 3'b101,
        SRC_EXT_BOTH = 3'b110,
        SRC_RSVD     = 3'b111
    } src_e;

    typedef struct packed {
        logic [DW-1:0]    ctrl;
        logic [DW-1:0]    cnt;
        logic [DW-1:0]    cmpa;
        logic [DW-1:0]    cmpb;
        logic [NFLAG-1:0] flags;
        logic [NFLAG-1:0] armed;
    } tmr_state_t;
endpackage

// File: rtl/cmp8_pin_sync.sv
// Multi-stage synchronizer that also keeps one extra sample for edge detection.
// smp[0] is the synchronized level, smp[1] the previous synchronized level.
module cmp8_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    output logic [1:0] smp
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[LEN-2:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign smp = {sh_q[LEN-1], sh_q[LEN-2]};
endmodule

// File: rtl/cmp8_tick_sel.sv
// Picks the count-enable for this cycle from the selected source.
module cmp8_tick_sel
    import cmp8_timer_pkg::*;
(
    input  src_e       sel,
    input  logic [2:0] pre_en,
    input  logic [1:0] ext_smp,
    output logic       tick
);
    logic rise, fall;

    always_comb begin
        rise = ext_smp[0] & ~ext_smp[1];
        fall = ~ext_smp[0] & ext_smp[1];
        unique case (sel)
            SRC_PRE0:     tick = pre_en[0];
            SRC_PRE1:     tick = pre_en[1];
            SRC_PRE2:     tick = pre_en[2];
            SRC_EXT_RISE: tick = rise;
            SRC_EXT_FALL: tick = fall;
            SRC_EXT_BOTH: tick = rise | fall;
            default:      tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmp8_timer.sv
module cmp8_timer
    import cmp8_timer_pkg::*;
#(
    parameter int            SYNC_STAGES = 2,
    parameter logic [DW-1:0] CMP_INIT    = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [2:0]    pre_en,
    input  logic          ext_clk,
    input  logic          ext_rst,
    output logic          irq_cmp_a,
    output logic          irq_cmp_b,
    output logic          irq_ovf
);
    tmr_state_t st_d, st_q;

    logic [1:0] clk_smp, rst_smp;
    logic       tick;
    src_e       src;
    clr_mode_e  clr_mode;

    cmp8_pin_sync #(.STAGES(SYNC_STAGES)) u_clk_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_clk), .smp(clk_smp)
    );

    cmp8_pin_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_rst), .smp(rst_smp)
    );

    assign src      = src_e'(st_q.ctrl[2:0]);
    assign clr_mode = clr_mode_e'(st_q.ctrl[4:3]);

    cmp8_tick_sel u_tick (
        .sel(src), .pre_en(pre_en), .ext_smp(clk_smp), .tick(tick)
    );

    logic             wr_cnt, wr_stat, rd_stat;
    logic             hit_a, hit_b, clr_hit, wrap, pin_clr;
    logic [NFLAG-1:0] hw_set;

    always_comb begin
        st_d    = st_q;
        wr_cnt  = wr_en && (addr == A_CNT);
        wr_stat = wr_en && (addr == A_STAT);
        rd_stat = rd_en && (addr == A_STAT);

        hit_a   = tick && (st_q.cnt == st_q.cmpa);
        hit_b   = tick && (st_q.cnt == st_q.cmpb);
        clr_hit = ((clr_mode == CLR_MATCH_A) && hit_a) ||
                  ((clr_mode == CLR_MATCH_B) && hit_b);
        wrap    = tick && !clr_hit && (st_q.cnt == {DW{1'b1}});
        pin_clr = (clr_mode == CLR_PIN) && rst_smp[0] && !rst_smp[1];

        // counter: count step, then pin clear, then bus write
        if (tick)    st_d.cnt = clr_hit ? '0 : st_q.cnt + 1'b1;
        if (pin_clr) st_d.cnt = '0;
        if (wr_cnt)  st_d.cnt = wdata;

        if (wr_en && addr == A_CTRL) st_d.ctrl = wdata;
        if (wr_en && addr == A_CMPA) st_d.cmpa = wdata;
        if (wr_en && addr == A_CMPB) st_d.cmpb = wdata;

        hw_set        = '0;
        hw_set[F_OVF] = wrap;
        hw_set[F_A]   = hit_a;
        hw_set[F_B]   = hit_b;

        for (int i = 0; i < NFLAG; i++) begin
            if (rd_stat && st_q.flags[i]) st_d.armed[i] = 1'b1;
            if (wr_stat && st_q.armed[i] && !wdata[FLAG_LSB + i]) begin
                st_d.flags[i] = 1'b0;
                st_d.armed[i] = 1'b0;
            end
            if (hw_set[i]) st_d.flags[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl  <= '0;
            st_q.cnt   <= '0;
            st_q.cmpa  <= CMP_INIT;
            st_q.cmpb  <= CMP_INIT;
            st_q.flags <= '0;
            st_q.armed <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = st_q.ctrl;
            A_STAT:  rdata = {st_q.flags, {FLAG_LSB{1'b0}}};
            A_CNT:   rdata = st_q.cnt;
            A_CMPA:  rdata = st_q.cmpa;
            A_CMPB:  rdata = st_q.cmpb;
            default: rdata = '0;
        endcase
    end

    assign irq_ovf   = st_q.flags[F_OVF] & st_q.ctrl[FLAG_LSB + F_OVF];
    assign irq_cmp_a = st_q.flags[F_A]   & st_q.ctrl[FLAG_LSB + F_A];
    assign irq_cmp_b = st_q.flags[F_B]   & st_q.ctrl[FLAG_LSB + F_B];
endmodule

// File: rtl/cmp8_timer_chk.sv
module cmp8_timer_chk
    import cmp8_timer_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic          tick,
    input tmr_state_t    st,
    input logic          irq_a,
    input logic          irq_b,
    input logic          irq_o
);
    logic wcnt, wstat;
    assign wcnt  = wr_en && (addr == A_CNT);
    assign wstat = wr_en && (addr == A_STAT);

    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wcnt |=> (st.cnt == $past(st.cnt) || st.cnt == $past(st.cnt) + 8'd1 || st.cnt == 8'd0));

    assert_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((st.ctrl[2:0] == 3'b000 || st.ctrl[2:0] == 3'b111) && st.ctrl[4:3] != 2'b11 && !wcnt)
        |=> $stable(st.cnt));

    assert_no_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st.ctrl[4:3] == 2'b00 && !wcnt && st.cnt != 8'd0 && st.cnt != 8'hFF) |=> st.cnt != 8'd0);

    assert_wrap_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st.ctrl[4:3] == 2'b00 && tick && st.cnt == 8'hFF) |=> st.flags[F_OVF]);

    assert_match_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st.cnt == st.cmpa) |=> st.flags[F_A]);

    assert_match_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st.cnt == st.cmpb) |=> st.flags[F_B]);

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wstat && st.flags != 3'b000) |=> (st.flags & $past(st.flags)) == $past(st.flags));

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_a |-> (st.flags[F_A] && st.ctrl[6])) and
        (irq_b |-> (st.flags[F_B] && st.ctrl[7])) and
        (irq_o |-> (st.flags[F_OVF] && st.ctrl[5])));
endmodule

bind cmp8_timer cmp8_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .tick(tick),
    .st(st_q), .irq_a(irq_cmp_a), .irq_b(irq_cmp_b), .irq_o(irq_ovf)
);

// File: tb/cmp8_timer_test.sv
`timescale 1ns/100ps
module cmp8_timer_test;
    localparam logic [2:0] R_CTRL = 3'd0, R_STAT = 3'd1, R_CNT = 3'd2,
                           R_CMPA = 3'd3, R_CMPB = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] pre_en = '0;
    logic       ext_clk = 1'b0, ext_rst = 1'b0;
    logic       irq_cmp_a, irq_cmp_b, irq_ovf;

    int checks = 0;
    int fails  = 0;

    cmp8_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pre_en(pre_en), .ext_clk(ext_clk),
        .ext_rst(ext_rst), .irq_cmp_a(irq_cmp_a), .irq_cmp_b(irq_cmp_b),
        .irq_ovf(irq_ovf)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic pulse(input int idx, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); pre_en[idx] = 1'b1;
            @(posedge clk); #1; pre_en[idx] = 1'b0;
        end
    endtask

    task automatic hold0(input int n);
        @(negedge clk); pre_en[0] = 1'b1;
        repeat (n) @(posedge clk);
        #1 pre_en[0] = 1'b0;
    endtask

    task automatic set_clk_pin(input logic v);
        @(negedge clk); ext_clk = v;
        repeat (4) @(posedge clk);
    endtask

    task automatic set_rst_pin(input logic v);
        @(negedge clk); ext_rst = v;
        repeat (4) @(posedge clk);
    endtask

    task automatic clear_flags();
        logic [7:0] v;
        rd(R_STAT, v);
        wr(R_STAT, 8'h00);
    endtask

    task automatic t_reset();
        rd_chk("R1 ctrl", R_CTRL, 8'h00);
        rd_chk("R1 status", R_STAT, 8'h00);
        rd_chk("R1 count", R_CNT, 8'h00);
        rd_chk("R1 cmpA", R_CMPA, 8'hFF);
        rd_chk("R1 cmpB", R_CMPB, 8'hFF);
        chk("R1 irqs", {5'd0, irq_cmp_b, irq_cmp_a, irq_ovf}, 8'h00);
    endtask

    task automatic t_internal();
        wr(R_CTRL, 8'h01); wr(R_CNT, 8'h00);
        pulse(1, 3); pulse(2, 2);
        rd_chk("R2 src 001 ignores other enables", R_CNT, 8'h00);
        pulse(0, 5);
        rd_chk("R2 src 001 counts pre_en0", R_CNT, 8'h05);
        wr(R_CTRL, 8'h02); wr(R_CNT, 8'h00);
        pulse(0, 2); pulse(1, 4);
        rd_chk("R2 src 010 counts pre_en1", R_CNT, 8'h04);
        wr(R_CTRL, 8'h03);
        pulse(2, 3);
        rd_chk("R2 src 011 counts pre_en2", R_CNT, 8'h07);
        wr(R_CTRL, 8'h00);
        pulse(0, 2); pulse(1, 2); pulse(2, 2);
        set_clk_pin(1'b1); set_clk_pin(1'b0);
        rd_chk("R2 src 000 stopped", R_CNT, 8'h07);
    endtask

    task automatic t_ext_clock();
        wr(R_CTRL, 8'h04); wr(R_CNT, 8'h00);
        for (int k = 0; k < 3; k++) begin set_clk_pin(1'b1); set_clk_pin(1'b0); end
        rd_chk("R3 rising edges", R_CNT, 8'h03);
        wr(R_CTRL, 8'h05); wr(R_CNT, 8'h00);
        set_clk_pin(1'b1);
        rd_chk("R3 falling mode ignores rise", R_CNT, 8'h00);
        set_clk_pin(1'b0); set_clk_pin(1'b1); set_clk_pin(1'b0);
        rd_chk("R3 falling edges", R_CNT, 8'h02);
        wr(R_CTRL, 8'h06); wr(R_CNT, 8'h00);
        for (int k = 0; k < 3; k++) begin set_clk_pin(1'b1); set_clk_pin(1'b0); end
        rd_chk("R3 both edges", R_CNT, 8'h06);
        wr(R_CTRL, 8'h07);
        set_clk_pin(1'b1); set_clk_pin(1'b0); pulse(0, 1);
        rd_chk("R2 reserved code stopped", R_CNT, 8'h06);
    endtask

    task automatic t_compare_clear();
        clear_flags();
        wr(R_CTRL, 8'h09); wr(R_CMPA, 8'h03); wr(R_CMPB, 8'hFF); wr(R_CNT, 8'h00);
        hold0(4);
        rd_chk("R5 clear on A count", R_CNT, 8'h00);
        rd_chk("R4 flag A set", R_STAT, 8'h40);
        hold0(2);
        rd_chk("R5 restarts from zero", R_CNT, 8'h02);
        wr(R_CTRL, 8'h11); wr(R_CMPA, 8'hFF); wr(R_CMPB, 8'h02); wr(R_CNT, 8'h00);
        hold0(3);
        rd_chk("R5 clear on B count", R_CNT, 8'h00);
        rd_chk("R4 flag B set", R_STAT, 8'hC0);
        wr(R_CTRL, 8'h01); wr(R_CMPA, 8'h02); wr(R_CMPB, 8'hFF); wr(R_CNT, 8'h00);
        hold0(3);
        rd_chk("R7 no clear in mode 00", R_CNT, 8'h03);
    endtask

    task automatic t_overflow();
        clear_flags();
        wr(R_CTRL, 8'h01); wr(R_CMPA, 8'hFF); wr(R_CMPB, 8'hFF); wr(R_CNT, 8'hFE);
        pulse(0, 1);
        rd_chk("R7 no flag before wrap", R_STAT, 8'h00);
        pulse(0, 1);
        rd_chk("R7 wraps to zero", R_CNT, 8'h00);
        rd_chk("R7 overflow and matches", R_STAT, 8'hE0);
        chk("R8 masked irqs low", {5'd0, irq_cmp_b, irq_cmp_a, irq_ovf}, 8'h00);
        wr(R_CTRL, 8'h21);
        #1 chk("R8 only ovf irq", {5'd0, irq_cmp_b, irq_cmp_a, irq_ovf}, 8'h01);
        wr(R_CTRL, 8'hC1);
        #1 chk("R8 A and B irqs", {5'd0, irq_cmp_b, irq_cmp_a, irq_ovf}, 8'h06);
        wr(R_CTRL, 8'h01);
    endtask

    task automatic t_flag_clear();
        clear_flags();
        rd_chk("R9 cleared after read", R_STAT, 8'h00);
        wr(R_CMPA, 8'h07); wr(R_CNT, 8'h07);
        pulse(0, 1);
        wr(R_STAT, 8'h00);
        rd_chk("R9 unread flag not cleared", R_STAT, 8'h40);
        wr(R_STAT, 8'hFF);
        rd_chk("R9 writing 1 no effect", R_STAT, 8'h40);
        wr(R_STAT, 8'h00);
        rd_chk("R9 read then write 0 clears", R_STAT, 8'h00);
    endtask

    task automatic t_hw_priority();
        clear_flags();
        wr(R_CTRL, 8'h09); wr(R_CMPA, 8'h05); wr(R_CNT, 8'h05);
        pulse(0, 1);
        rd_chk("R10 flag A set", R_STAT, 8'h40);
        wr(R_CNT, 8'h05);
        @(negedge clk);
        wr_en = 1'b1; addr = R_STAT; wdata = 8'h00; pre_en[0] = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; pre_en[0] = 1'b0;
        rd_chk("R10 set wins over clear", R_STAT, 8'h40);
        wr(R_STAT, 8'h00);
        rd_chk("R10 later clear works", R_STAT, 8'h00);
    endtask

    task automatic t_ext_reset();
        wr(R_CTRL, 8'h19); wr(R_CNT, 8'h40);
        set_rst_pin(1'b1);
        rd_chk("R6 pin rise clears", R_CNT, 8'h00);
        wr(R_CNT, 8'h40);
        set_rst_pin(1'b0);
        rd_chk("R6 falling edge ignored", R_CNT, 8'h40);
        wr(R_CTRL, 8'h01);
        set_rst_pin(1'b1);
        rd_chk("R6 ignored in mode 00", R_CNT, 8'h40);
        set_rst_pin(1'b0);
    endtask

    task automatic t_write_priority();
        wr(R_CTRL, 8'h01); wr(R_CNT, 8'h20);
        @(negedge clk);
        wr_en = 1'b1; addr = R_CNT; wdata = 8'h10; pre_en[0] = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; pre_en[0] = 1'b0;
        rd_chk("R11 write beats count", R_CNT, 8'h10);
        rd_chk("R11 unused address", 3'd5, 8'h00);
        rd_chk("R11 unused address 7", 3'd7, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_internal();
        t_ext_clock();
        t_compare_clear();
        t_overflow();
        t_flag_clear();
        t_hw_priority();
        t_ext_reset();
        t_write_priority();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule